// File: doc/BRIEF.md
# Data-Access Breakpoint Match Channel

This block is one hardware breakpoint channel. It keeps a stored condition: an address, an address mask, a data value, a data mask and a 10-bit cycle-condition word. It watches every processor bus cycle that a strobe marks valid. When a cycle meets the stored condition, the block raises a one-cycle break request on the next clock.

Software-side decoding is outside the block. A single write strobe loads all configuration fields at once. The cycle-condition word selects:

- the access kind: instruction fetch, data access, or either;
- the direction;
- the operand size;
- which processor bus is watched;
- whether the data value takes part in the match;
- a dedicated X/Y-memory mode. In this mode each 32-bit address and data register is split into two 16-bit halves, one half for each memory.

Prefetch cycles are handled as longword data reads. They can never break while a data condition is enabled.

Top module: `bkpt_match_chan`

## Requirements
- R1: Synchronous reset clears brk_o and every stored field. A cleared kind field (0) never matches, so no break can occur until the configuration is written.
- R2: With cfg_we high at a clock edge, all configuration inputs are stored. The stored values govern bus cycles from the next edge on. The condition word layout is: kind [1:0], dir [3:2], size [5:4], bus select [6], data enable [7], X/Y enable [8], X/Y select [9].
- R3: A 1 in the address mask makes that address bit a don't-care. A 0 requires equality with the stored address.
- R4: The kind field values are: 0 never, 1 fetch cycles only (bus_fetch=1), 2 data cycles only, 3 both.
- R5: The direction field values are: 0 never, 1 reads only, 2 writes only, 3 either.
- R6: The size field values are: 0 any size, 1 byte, 2 word, 3 longword. A non-zero value must equal bus_size, which uses the same codes 1, 2 and 3.
- R7: With data enable set, a break needs both the address and the data to match on the same cycle. For longword size all 32 masked data bits are compared.
- R8: For word and byte compares, bits 31:16 of the data value and data mask are ignored. A word compare checks bus_data[15:0] against bits 15:0.
- R9: A byte compare hits when bus_data[7:0] matches value bits 7:0, or when bus_data[15:8] matches value bits 15:8, each under its mask.
- R10: A prefetch cycle (bus_pref=1) is taken as a longword data read, whatever bus_size, bus_write and bus_fetch say. With data enable set, a prefetch never breaks.
- R11: Outside X/Y mode, a cycle can match only if bus_id equals the bus select bit: 0 for the core data bus, 1 for the internal bus. X/Y cycles (bus_id 2 or 3) never match outside X/Y mode.
- R12: In X/Y mode a cycle can match only on bus_id 2 when the select bit is 0, or on bus_id 3 when it is 1. The condition must also have bus select 0, kind 2, a non-zero direction, and size 0 or 2. Otherwise nothing matches.
- R13: In X/Y mode with select 0, bus_addr[15:0] and bus_data[15:0] are compared against the upper halves of the stored value and mask. With select 1 they are compared against the lower halves.
- R14: brk_o is high for exactly the cycle after each valid matching bus cycle. It is never high for a cycle presented without bus_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_addr_i | input | 32 | Address value to store |
| cfg_amask_i | input | 32 | Address mask to store (1 = don't care) |
| cfg_data_i | input | 32 | Data value to store |
| cfg_dmask_i | input | 32 | Data mask to store (1 = don't care) |
| cfg_cond_i | input | 10 | Cycle-condition word |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_size | input | 2 | Operand size: 1 byte, 2 word, 3 longword |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_pref | input | 1 | Prefetch cycle |
| bus_id | input | 2 | 0 core data bus, 1 internal bus, 2 X memory, 3 Y memory |
| brk_o | output | 1 | Registered break pulse |

## Verification
A configuration write takes effect one edge after cfg_we. A bus cycle driven before an edge has its break result on brk_o right after that same edge. Each directed task therefore loads its condition, drives a cycle at a falling edge, and samples brk_o at the next falling edge, half a period after the registering edge. The bus strobe is then dropped, so every sample belongs to exactly one presented cycle. A pulse that lasted too long would show up as a 1 on a following idle cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        KIND_OFF   = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_DATA  = 2'd2,
        KIND_ANY   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        DIR_OFF = 2'd0,
        DIR_RD  = 2'd1,
        DIR_WR  = 2'd2,
        DIR_ANY = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        SZ_ANY  = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } size_e;

    localparam logic [1:0] BUS_CORE = 2'd0;
    localparam logic [1:0] BUS_SYS  = 2'd1;
    localparam logic [1:0] BUS_XMEM = 2'd2;
    localparam logic [1:0] BUS_YMEM = 2'd3;

    // Packed MSB first: xy_sel is bit 9, kind is bits 1:0.
    typedef struct packed {
        logic  xy_sel;
        logic  xy_en;
        logic  data_en;
        logic  bus_sys;
        size_e size;
        dir_e  dir;
        kind_e kind;
    } cond_t;

    localparam int COND_W = $bits(cond_t);

endpackage

// File: rtl/bkpt_mask_cmp.sv
module bkpt_mask_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] ref_v,
    input  logic [W-1:0] ref_m,
    output logic         hit
);
    // A mask bit of 1 removes that bit from the comparison.
    assign hit = ((val ^ ref_v) & ~ref_m) == '0;
endmodule

// File: rtl/bkpt_data_cmp.sv
module bkpt_data_cmp
    import bkpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] bus_data,
    input  logic [DATA_W-1:0] ref_v,
    input  logic [DATA_W-1:0] ref_m,
    input  size_e             cmp_size,
    input  logic              xy_mode,
    input  logic              xy_upper,
    output logic              hit
);
    localparam int NLANE = DATA_W / 8;
    localparam int DH    = DATA_W / 2;

    logic [NLANE-1:0] lane_hit;
    logic [DH-1:0]    half_v;
    logic [DH-1:0]    half_m;
    logic             half_hit;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        bkpt_mask_cmp #(.W(8)) i_lane (
            .val   (bus_data[8*l +: 8]),
            .ref_v (ref_v[8*l +: 8]),
            .ref_m (ref_m[8*l +: 8]),
            .hit   (lane_hit[l])
        );
    end

    assign half_v = xy_upper ? ref_v[DATA_W-1:DH] : ref_v[DH-1:0];
    assign half_m = xy_upper ? ref_m[DATA_W-1:DH] : ref_m[DH-1:0];

    bkpt_mask_cmp #(.W(DH)) i_half (
        .val   (bus_data[DH-1:0]),
        .ref_v (half_v),
        .ref_m (half_m),
        .hit   (half_hit)
    );

    always_comb begin
        if (xy_mode) begin
            hit = half_hit;
        end else begin
            unique case (cmp_size)
                SZ_BYTE: hit = lane_hit[0] | lane_hit[1];
                SZ_WORD: hit = lane_hit[0] & lane_hit[1];
                default: hit = &lane_hit;
            endcase
        end
    end
endmodule

// File: rtl/bkpt_match_chan.sv
module bkpt_match_chan
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr_i,
    input  logic [ADDR_W-1:0]   cfg_amask_i,
    input  logic [DATA_W-1:0]   cfg_data_i,
    input  logic [DATA_W-1:0]   cfg_dmask_i,
    input  logic [COND_W-1:0]   cfg_cond_i,
    input  logic                bus_valid,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_data,
    input  logic [1:0]          bus_size,
    input  logic                bus_write,
    input  logic                bus_fetch,
    input  logic                bus_pref,
    input  logic [1:0]          bus_id,
    output logic                brk_o
);
    localparam int AH = ADDR_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] amask;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] dmask;
        cond_t             cond;
        logic              brk;
    } state_t;

    state_t state_d, state_q;
    cond_t  c;

    logic   eff_fetch, eff_write;
    size_e  eff_size, cmp_size;
    logic   kind_ok, dir_ok, size_ok, route_ok, data_ok;
    logic   full_hit, half_hit, addr_hit, data_hit;
    logic [AH-1:0] half_v, half_m;

    assign c = state_q.cond;

    // Address comparators: full width, and one 16-bit half for X/Y mode.
    assign half_v = c.xy_sel ? state_q.addr[AH-1:0]  : state_q.addr[ADDR_W-1:AH];
    assign half_m = c.xy_sel ? state_q.amask[AH-1:0] : state_q.amask[ADDR_W-1:AH];

    bkpt_mask_cmp #(.W(ADDR_W)) i_addr_full (
        .val   (bus_addr),
        .ref_v (state_q.addr),
        .ref_m (state_q.amask),
        .hit   (full_hit)
    );

    bkpt_mask_cmp #(.W(AH)) i_addr_half (
        .val   (bus_addr[AH-1:0]),
        .ref_v (half_v),
        .ref_m (half_m),
        .hit   (half_hit)
    );

    assign addr_hit = c.xy_en ? half_hit : full_hit;
    assign cmp_size = (c.size == SZ_ANY) ? eff_size : c.size;

    bkpt_data_cmp #(.DATA_W(DATA_W)) i_data (
        .bus_data (bus_data),
        .ref_v    (state_q.data),
        .ref_m    (state_q.dmask),
        .cmp_size (cmp_size),
        .xy_mode  (c.xy_en),
        .xy_upper (~c.xy_sel),
        .hit      (data_hit)
    );

    always_comb begin
        // A prefetch looks like a longword data read.
        eff_fetch = bus_fetch & ~bus_pref;
        eff_write = bus_write & ~bus_pref;
        eff_size  = bus_pref ? SZ_LONG : size_e'(bus_size);

        unique case (c.kind)
            KIND_FETCH: kind_ok = eff_fetch;
            KIND_DATA:  kind_ok = ~eff_fetch;
            KIND_ANY:   kind_ok = 1'b1;
            default:    kind_ok = 1'b0;
        endcase

        unique case (c.dir)
            DIR_RD:  dir_ok = ~eff_write;
            DIR_WR:  dir_ok = eff_write;
            DIR_ANY: dir_ok = 1'b1;
            default: dir_ok = 1'b0;
        endcase

        size_ok = (c.size == SZ_ANY) || (c.size == eff_size);

        if (c.xy_en) begin
            route_ok = (bus_id == {1'b1, c.xy_sel}) && !c.bus_sys &&
                       (c.kind == KIND_DATA) &&
                       ((c.size == SZ_ANY) || (c.size == SZ_WORD));
        end else begin
            route_ok = (bus_id == {1'b0, c.bus_sys});
        end

        data_ok = !c.data_en || (data_hit && !bus_pref);

        state_d     = state_q;
        state_d.brk = bus_valid & kind_ok & dir_ok & size_ok & route_ok &
                      addr_hit & data_ok;
        if (cfg_we) begin
            state_d.addr  = cfg_addr_i;
            state_d.amask = cfg_amask_i;
            state_d.data  = cfg_data_i;
            state_d.dmask = cfg_dmask_i;
            state_d.cond  = cond_t'(cfg_cond_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign brk_o = state_q.brk;

endmodule

// File: rtl/bkpt_match_chk.sv
module bkpt_match_chk
    import bkpt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_valid,
    input logic       bus_pref,
    input logic       bus_fetch,
    input logic [1:0] bus_id,
    input cond_t      cond,
    input logic       brk
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!brk && cond.kind == KIND_OFF));

    // R14
    brk_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        brk |-> $past(bus_valid));

    // R10
    pref_data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        brk |-> !($past(bus_pref) && $past(cond.data_en)));

    // R12
    xy_route_chk: assert property (@(posedge clk) disable iff (rst)
        (brk && $past(cond.xy_en)) |-> ($past(bus_id) == {1'b1, $past(cond.xy_sel)}));

    // R11
    bus_route_chk: assert property (@(posedge clk) disable iff (rst)
        (brk && !$past(cond.xy_en)) |-> ($past(bus_id) == {1'b0, $past(cond.bus_sys)}));

    // R4
    fetch_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (brk && $past(cond.kind) == KIND_FETCH) |-> ($past(bus_fetch) && !$past(bus_pref)));
endmodule

bind bkpt_match_chan bkpt_match_chk i_bkpt_match_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_pref  (bus_pref),
    .bus_fetch (bus_fetch),
    .bus_id    (bus_id),
    .cond      (state_q.cond),
    .brk       (brk_o)
);

// File: tb/test_bkpt_match_chan.sv
module test_bkpt_match_chan;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_addr_i, cfg_amask_i, cfg_data_i, cfg_dmask_i;
    logic [9:0]  cfg_cond_i;
    logic        bus_valid;
    logic [31:0] bus_addr, bus_data;
    logic [1:0]  bus_size;
    logic        bus_write, bus_fetch, bus_pref;
    logic [1:0]  bus_id;
    logic        brk_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_match_chan i_bkpt_match_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_addr_i(cfg_addr_i), .cfg_amask_i(cfg_amask_i),
        .cfg_data_i(cfg_data_i), .cfg_dmask_i(cfg_dmask_i),
        .cfg_cond_i(cfg_cond_i), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_size(bus_size),
        .bus_write(bus_write), .bus_fetch(bus_fetch), .bus_pref(bus_pref),
        .bus_id(bus_id), .brk_o(brk_o)
    );

    // Condition word: {xy_sel, xy_en, data_en, bus_sys, size[1:0], dir[1:0], kind[1:0]}
    function automatic logic [9:0] mk(input logic xs, input logic xe, input logic de,
                                      input logic bs, input logic [1:0] sz,
                                      input logic [1:0] dr, input logic [1:0] kd);
        return {xs, xe, de, bs, sz, dr, kd};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] a, input logic [31:0] am,
                        input logic [31:0] d, input logic [31:0] dm, input logic [9:0] c);
        cfg_addr_i = a; cfg_amask_i = am; cfg_data_i = d; cfg_dmask_i = dm;
        cfg_cond_i = c; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one cycle at a falling edge, sample brk_o at the next falling edge.
    task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                       input logic wr, input logic ft, input logic pf,
                       input logic [1:0] id, input logic vld, output logic b);
        bus_addr = a; bus_data = d; bus_size = sz; bus_write = wr;
        bus_fetch = ft; bus_pref = pf; bus_id = id; bus_valid = vld;
        @(negedge clk);
        b = brk_o;
        bus_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic b;
        chk("R1 brk during reset", brk_o, 1'b0);
        cyc(32'h0, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R1 cleared config never matches", b, 1'b0);
    endtask

    task automatic t_addr;
        logic b;
        load(32'h1234_5678, 32'h0000_00FF, 32'h0, 32'h0, mk(0,0,0,0,2'd0,2'd3,2'd3));
        cyc(32'h1234_56AB, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R2 R3 masked address hit", b, 1'b1);
        cyc(32'h1234_56AB, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, b);
        chk("R14 single pulse, no break without valid", b, 1'b0);
        cyc(32'h1334_5678, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R3 unmasked bit differs", b, 1'b0);
    endtask

    task automatic t_kind;
        logic b;
        load(32'h100, 32'h0, 32'h0, 32'h0, mk(0,0,0,0,2'd0,2'd3,2'd1));
        cyc(32'h100, 32'h0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, b);
        chk("R4 fetch kind on fetch", b, 1'b1);
        cyc(32'h100, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R4 fetch kind on data", b, 1'b0);
        load(32'h100, 32'h0, 32'h0, 32'h0, mk(0,0,0,0,2'd0,2'd3,2'd2));
        cyc(32'h100, 32'h0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, b);
        chk("R4 data kind on fetch", b, 1'b0);
        cyc(32'h100, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R4 data kind on data", b, 1'b1);
    endtask

    task automatic t_dir;
        logic b;
        load(32'h200, 32'h0, 32'h0, 32'h0, mk(0,0,0,0,2'd0,2'd1,2'd3));
        cyc(32'h200, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R5 read dir on read", b, 1'b1);
        cyc(32'h200, 32'h0, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R5 read dir on write", b, 1'b0);
        load(32'h200, 32'h0, 32'h0, 32'h0, mk(0,0,0,0,2'd0,2'd2,2'd3));
        cyc(32'h200, 32'h0, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R5 write dir on write", b, 1'b1);
        load(32'h200, 32'h0, 32'h0, 32'h0, mk(0,0,0,0,2'd0,2'd0,2'd3));
        cyc(32'h200, 32'h0, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R5 dir zero never", b, 1'b0);
    endtask

    task automatic t_size;
        logic b;
        load(32'h300, 32'h0, 32'h0, 32'h0, mk(0,0,0,0,2'd2,2'd3,2'd3));
        cyc(32'h300, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R6 word on word", b, 1'b1);
        cyc(32'h300, 32'h0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R6 word on byte", b, 1'b0);
        cyc(32'h300, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R6 word on long", b, 1'b0);
    endtask

    task automatic t_data;
        logic b;
        load(32'h400, 32'h0, 32'hDEAD_BEEF, 32'h0, mk(0,0,1,0,2'd3,2'd3,2'd2));
        cyc(32'h400, 32'hDEAD_BEEF, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R7 long addr+data hit", b, 1'b1);
        cyc(32'h404, 32'hDEAD_BEEF, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R7 data only", b, 1'b0);
        cyc(32'h400, 32'h5EAD_BEEF, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R7 upper data bit differs", b, 1'b0);
        load(32'h400, 32'h0, 32'hFFFF_1234, 32'h0, mk(0,0,1,0,2'd2,2'd3,2'd2));
        cyc(32'h400, 32'h0000_1234, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R8 word ignores upper value", b, 1'b1);
        cyc(32'h400, 32'h0000_1235, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R8 word low bit differs", b, 1'b0);
        load(32'h400, 32'h0, 32'h0000_5A5A, 32'h0, mk(0,0,1,0,2'd1,2'd3,2'd2));
        cyc(32'h400, 32'h0000_005A, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R9 byte low lane", b, 1'b1);
        cyc(32'h400, 32'h0000_5A00, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R9 byte high lane", b, 1'b1);
        cyc(32'h400, 32'h0000_0033, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, b);
        chk("R9 byte no lane", b, 1'b0);
    endtask

    task automatic t_pref;
        logic b;
        load(32'h500, 32'h0, 32'h0000_0077, 32'h0, mk(0,0,0,0,2'd3,2'd1,2'd2));
        cyc(32'h500, 32'h0000_0077, 2'd1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, b);
        chk("R10 prefetch as long data read", b, 1'b1);
        load(32'h500, 32'h0, 32'h0000_0077, 32'h0, mk(0,0,1,0,2'd3,2'd1,2'd2));
        cyc(32'h500, 32'h0000_0077, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, b);
        chk("R10 prefetch with data enable", b, 1'b0);
    endtask

    task automatic t_bus;
        logic b;
        load(32'h600, 32'h0, 32'h0, 32'h0, mk(0,0,0,0,2'd0,2'd3,2'd3));
        cyc(32'h600, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, b);
        chk("R11 core select on internal bus", b, 1'b0);
        cyc(32'h600, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, b);
        chk("R11 X/Y cycle outside X/Y mode", b, 1'b0);
        load(32'h600, 32'h0, 32'h0, 32'h0, mk(0,0,0,1,2'd0,2'd3,2'd3));
        cyc(32'h600, 32'h0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, b);
        chk("R11 internal select on internal bus", b, 1'b1);
    endtask

    task automatic t_xy;
        logic b;
        load(32'hA000_B000, 32'h0, 32'h1111_2222, 32'h0, mk(0,1,1,0,2'd2,2'd3,2'd2));
        cyc(32'h0000_A000, 32'h0000_1111, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, b);
        chk("R13 X mode upper halves", b, 1'b1);
        cyc(32'h0000_A000, 32'h0000_1111, 2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, b);
        chk("R12 X mode on Y cycle", b, 1'b0);
        cyc(32'h0000_B000, 32'h0000_1111, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, b);
        chk("R13 X mode lower address half", b, 1'b0);
        load(32'hA000_B000, 32'h0, 32'h1111_2222, 32'h0, mk(1,1,1,0,2'd0,2'd1,2'd2));
        cyc(32'h0000_B000, 32'h0000_2222, 2'd2, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, b);
        chk("R13 Y mode lower halves", b, 1'b1);
        load(32'hA000_B000, 32'h0, 32'h1111_2222, 32'h0, mk(1,1,1,0,2'd3,2'd1,2'd2));
        cyc(32'h0000_B000, 32'h0000_2222, 2'd3, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, b);
        chk("R12 X/Y with long size", b, 1'b0);
        load(32'hA000_B000, 32'h0, 32'h1111_2222, 32'h0, mk(1,1,1,1,2'd2,2'd1,2'd2));
        cyc(32'h0000_B000, 32'h0000_2222, 2'd2, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, b);
        chk("R12 X/Y with internal bus select", b, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R14 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0;
        cfg_addr_i = '0; cfg_amask_i = '0; cfg_data_i = '0; cfg_dmask_i = '0;
        cfg_cond_i = '0; bus_valid = 1'b0; bus_addr = '0; bus_data = '0;
        bus_size = 2'd3; bus_write = 1'b0; bus_fetch = 1'b0; bus_pref = 1'b0;
        bus_id = 2'd0;
        repeat (3) @(negedge clk);
        t_reset_during();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr();
        t_kind();
        t_dir();
        t_size();
        t_data();
        t_pref();
        t_bus();
        t_xy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic t_reset_during;
        chk("R1 brk low in reset", brk_o, 1'b0);
    endtask
endmodule